// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block produces the system reset for a processor from three sources: a supply-good flag from an external comparator, an active-low push-button style manual reset and a watchdog kick line driven by software. Reset is asserted at once whenever the supply is reported bad. After every cause of reset has gone away, reset is held for a fixed number of clock cycles before release. The block gives the reset in both polarities.

Once reset is released, a watchdog counter starts from zero. Every rising or falling transition of the kick line restarts it. If the count reaches the timeout with no transition, the block raises a timed reset pulse that is exactly as long as the release delay. The watchdog then starts again from zero. Kick transitions that arrive while reset is asserted have no effect. Both lengths are parameters in clock cycles. The manual reset and kick lines pass through a synchroniser. The supply-good flag must already be synchronous to the clock.

Top module: `reset_guard`

## Requirements
- R1: While `supply_ok` is 0, `rst_o` is 1 in the same cycle, with no synchroniser or delay on that path.
- R2: While `por_n` is low, `rst_o` is 1. With `supply_ok`=1 and `mr_n`=1, `rst_o` falls after exactly DELAY_CYC rising clock edges following the release of `por_n`.
- R3: When `supply_ok` returns to 1, with no other cause present, `rst_o` stays 1 for exactly DELAY_CYC more rising edges.
- R4: A low level on `mr_n` sets `rst_o` after 2 rising edges (synchroniser). After `mr_n` returns high, `rst_o` falls after exactly DELAY_CYC+2 rising edges.
- R5: Once reset is released, if `wd_kick` makes no transition, `rst_o` stays 0 for exactly TOUT_CYC rising edges and then rises.
- R6: A watchdog timeout holds `rst_o` at 1 for exactly DELAY_CYC edges. The watchdog then restarts from zero, so a further TOUT_CYC quiet edges repeat the timeout.
- R7: Both rising and falling transitions of `wd_kick` restart the watchdog. Transitions spaced closer than TOUT_CYC-3 cycles keep `rst_o` at 0.
- R8: `wd_kick` transitions made while `rst_o` is 1 are ignored. After release, the timeout still takes exactly TOUT_CYC edges.
- R9: `rst_n_o` is always the complement of `rst_o`.
- R10: A supply drop during the release delay restarts the full delay. `rst_o` falls DELAY_CYC edges after the last recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous clear of the supervisor logic, active low |
| supply_ok | input | 1 | Supply above threshold, synchronous to clk, 1 = good |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| wd_kick | input | 1 | Watchdog service line, either edge services, asynchronous |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |

## Verification
The properties assume that `supply_ok` changes only between clock edges and that `por_n` is low from time zero. They also assume the two lengths are at least 2 cycles. The bench drives every input on the falling clock edge, so `supply_ok` is always sampled cleanly. It keeps each manual reset pulse longer than the synchroniser depth. In the directed cases it stops changing `wd_kick` several cycles before a release, so no kick is still in flight in the synchroniser when the exact timeout lengths are measured.

// File: rtl/reset_guard_pkg.sv
package reset_guard_pkg;
  // width of a counter that must hold values 0..len
  function automatic int unsigned cnt_width(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction

  // true on the final tick of a window of len cycles counted from 0
  function automatic logic last_tick(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction
endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) pipe <= INIT;
        else         pipe <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) pipe <= {STAGES{INIT}};
        else         pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rg_hold_timer.sv
module rg_hold_timer
  import reset_guard_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 20,
  localparam int unsigned W = cnt_width(DELAY_CYC)
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         cause,
  output logic         hold,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else if (cause) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else if (hold) begin
      if (last_tick(32'(cnt), DELAY_CYC)) begin
        hold <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rg_wd_timer.sv
module rg_wd_timer
  import reset_guard_pkg::*;
#(
  parameter int unsigned TOUT_CYC = 50,
  localparam int unsigned W = cnt_width(TOUT_CYC)
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         rst_act,
  input  logic         kick,
  output logic         expire,
  output logic [W-1:0] cnt
);
  assign expire = !rst_act && !kick && last_tick(32'(cnt), TOUT_CYC);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                         cnt <= '0;
    else if (rst_act || kick || expire)  cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/reset_guard.sv
module reset_guard
  import reset_guard_pkg::*;
#(
  parameter int unsigned DELAY_CYC   = 9_000_000,
  parameter int unsigned TOUT_CYC    = 40_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wd_kick,
  output logic rst_n_o,
  output logic rst_o
);
  localparam int unsigned DW = cnt_width(DELAY_CYC);
  localparam int unsigned WW = cnt_width(TOUT_CYC);

  logic          mr_s, wd_s, wd_prev;
  logic          kick_edge, rst_act, cause, hold, wd_expire;
  logic [DW-1:0] hold_cnt;
  logic [WW-1:0] wd_cnt;

  rg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_mr_sync (
    .clk(clk), .arst_n(por_n), .d(mr_n), .q(mr_s));

  rg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_wd_sync (
    .clk(clk), .arst_n(por_n), .d(wd_kick), .q(wd_s));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) wd_prev <= 1'b0;
    else        wd_prev <= wd_s;

  assign kick_edge = wd_s ^ wd_prev;
  assign rst_act   = hold | !supply_ok | !mr_s;
  assign cause     = !supply_ok | !mr_s | wd_expire;

  rg_hold_timer #(.DELAY_CYC(DELAY_CYC)) u_hold (
    .clk(clk), .arst_n(por_n), .cause(cause), .hold(hold), .cnt(hold_cnt));

  rg_wd_timer #(.TOUT_CYC(TOUT_CYC)) u_wd (
    .clk(clk), .arst_n(por_n), .rst_act(rst_act), .kick(kick_edge),
    .expire(wd_expire), .cnt(wd_cnt));

  assign rst_o   = rst_act;
  assign rst_n_o = !rst_act;
endmodule

// File: rtl/reset_guard_chk.sv
module reset_guard_chk
  import reset_guard_pkg::*;
#(
  parameter int unsigned TOUT_CYC  = 50,
  parameter int unsigned DELAY_CYC = 20,
  localparam int unsigned WW = cnt_width(TOUT_CYC),
  localparam int unsigned DW = cnt_width(DELAY_CYC)
) (
  input logic          clk,
  input logic          por_n,
  input logic          supply_ok,
  input logic          rst_o,
  input logic          rst_n_o,
  input logic          cause,
  input logic          kick_edge,
  input logic          wd_expire,
  input logic [WW-1:0] wd_cnt,
  input logic [DW-1:0] hold_cnt
);
  p_supply_low_r1: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |-> rst_o);

  p_cause_holds_r3: assert property (@(posedge clk) disable iff (!por_n)
    cause |=> (rst_o && hold_cnt == '0));

  p_release_quiet_r10: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_o) |-> !$past(cause));

  p_expire_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> (rst_o && wd_cnt == '0));

  p_expire_running_r5: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |-> !rst_o);

  p_kick_ignored_r8: assert property (@(posedge clk) disable iff (!por_n)
    (rst_o && kick_edge) |=> wd_cnt == '0);

  p_polarity_r9: assert property (@(posedge clk) disable iff (!por_n)
    rst_o != rst_n_o);
endmodule

bind reset_guard reset_guard_chk #(.TOUT_CYC(TOUT_CYC), .DELAY_CYC(DELAY_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .rst_o(rst_o),
  .rst_n_o(rst_n_o), .cause(cause), .kick_edge(kick_edge),
  .wd_expire(wd_expire), .wd_cnt(wd_cnt), .hold_cnt(hold_cnt));

// File: tb/reset_guard_bench.sv
module reset_guard_bench;
  localparam int D = 20;
  localparam int T = 50;

  logic clk = 1'b0;
  logic por_n = 1'b0, supply_ok = 1'b1, mr_n = 1'b1, wd_kick = 1'b0;
  logic rst_n_o, rst_o;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  reset_guard #(.DELAY_CYC(D), .TOUT_CYC(T), .SYNC_STAGES(2)) u_reset_guard (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .mr_n(mr_n),
    .wd_kick(wd_kick), .rst_n_o(rst_n_o), .rst_o(rst_o));

  // reference model written from the requirements
  bit m_mr1, m_mr2, m_w1, m_w2, m_wp, m_hold;
  int m_q, m_wc;
  bit t_rst, t_kick, t_exp, t_cause;

  function automatic bit exp_rst();
    return m_hold | !supply_ok | !m_mr2;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_mr1 <= 1; m_mr2 <= 1; m_w1 <= 0; m_w2 <= 0; m_wp <= 0;
      m_hold <= 1; m_q <= 0; m_wc <= 0;
    end else begin
      t_rst   = exp_rst();
      t_kick  = (m_w2 != m_wp);
      t_exp   = !t_rst && !t_kick && (m_wc == T - 1);
      t_cause = !supply_ok || !m_mr2 || t_exp;
      m_mr1 <= mr_n; m_mr2 <= m_mr1;
      m_w1 <= wd_kick; m_w2 <= m_w1; m_wp <= m_w2;
      if (t_cause) begin m_hold <= 1; m_q <= 0; end
      else if (m_hold) begin
        if (m_q == D - 1) begin m_hold <= 0; m_q <= 0; end
        else m_q <= m_q + 1;
      end
      if (t_rst || t_kick || t_exp) m_wc <= 0;
      else m_wc <= m_wc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic measure_high(output int n);
    n = 0;
    while (rst_o === 1'b1 && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (rst_o === 1'b0 && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int rnd;
    bit kicking;
    rnd = $urandom(32'h5eed);
    // R2 reset state
    repeat (3) @(negedge clk);
    chk(rst_o === 1'b1, "R2 reset state rst_o", rst_o, 1);
    chk(rst_n_o === 1'b0, "R9 reset state rst_n_o", rst_n_o, 0);
    por_n = 1'b1;
    measure_high(n);
    chk(n == D, "R2 power-on delay", n, D);
    // R5 and R6 watchdog timeout and restart
    measure_low(n);
    chk(n == T, "R5 timeout length", n, T);
    measure_high(n);
    chk(n == D, "R6 timeout pulse length", n, D);
    // R7 both edges service the watchdog
    n = 0;
    for (int i = 0; i < 8; i++) begin
      wd_kick = ~wd_kick;
      repeat (T / 2) begin
        @(negedge clk);
        if (rst_o !== 1'b0) n++;
      end
    end
    chk(n == 0, "R7 kicks keep reset off", n, 0);
    // R4 manual reset latency, R8 kicks during reset
    mr_n = 1'b0;
    #1 chk(rst_o === 1'b0, "R4 before sync", rst_o, 0);
    @(negedge clk);
    chk(rst_o === 1'b0, "R4 after one edge", rst_o, 0);
    @(negedge clk);
    chk(rst_o === 1'b1, "R4 after two edges", rst_o, 1);
    for (int i = 0; i < 4; i++) begin
      repeat (2) @(negedge clk);
      wd_kick = ~wd_kick;
    end
    repeat (8) @(negedge clk);
    mr_n = 1'b1;
    measure_high(n);
    chk(n == D + 2, "R4 release after manual reset", n, D + 2);
    measure_low(n);
    chk(n == T, "R8 timeout after ignored kicks", n, T);
    measure_high(n);
    chk(n == D, "R6 second timeout pulse", n, D);
    // R1 and R3 supply drop
    repeat (3) @(negedge clk);
    supply_ok = 1'b0;
    #1 chk(rst_o === 1'b1, "R1 same-cycle assert", rst_o, 1);
    chk(rst_n_o === 1'b0, "R9 during supply drop", rst_n_o, 0);
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    measure_high(n);
    chk(n == D, "R3 recovery delay", n, D);
    // R10 drop during the delay restarts it
    @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (D / 2) @(negedge clk);
    chk(rst_o === 1'b1, "R10 mid delay", rst_o, 1);
    supply_ok = 1'b0;
    #1 chk(rst_o === 1'b1, "R1 drop during delay", rst_o, 1);
    @(negedge clk);
    supply_ok = 1'b1;
    measure_high(n);
    chk(n == D, "R10 restarted delay", n, D);
    // random phase against the model
    kicking = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i % 500 == 0) kicking = ~kicking;
      rnd = $urandom % 1000;
      if (supply_ok) begin if (rnd < 3) supply_ok = 1'b0; end
      else if (rnd < 200) supply_ok = 1'b1;
      rnd = $urandom % 1000;
      if (mr_n) begin if (rnd < 3) mr_n = 1'b0; end
      else if (rnd < 150) mr_n = 1'b1;
      if (kicking && ($urandom % 20 == 0)) wd_kick = ~wd_kick;
      #1;
      chk(rst_o === exp_rst(), "R5 random model rst_o", rst_o, exp_rst());
      chk(rst_n_o === !exp_rst(), "R9 random model rst_n_o", rst_n_o, !exp_rst());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule